// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Unit

This unit gathers fourteen single-cycle event pulses from neighbouring logic into sticky status bits. It combines every source that is both pending and enabled into one registered interrupt request. Software sets enables with a write-1 enable strobe and removes them with a separate write-1 disable strobe. Writing a 0 in either word leaves that bit alone. The enable state reads back as a mask in which 1 means the source is disabled.

Reading the status word returns the pending bits and clears them at the same clock edge. An event that arrives in the cycle of the read is kept for the next read. Status bits latch whether or not their source is enabled. The enable state gates only the interrupt output.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, statData is 0, maskData is all ones (every source disabled) and irqOut is 0.
- R2: An evtIn bit that is high for one cycle sets the matching statData bit at the next clock edge. The bit is set even when that source is disabled, and it stays set until a status read.
- R3: When statRd is high, statData shows the current status. At the next edge every status bit is cleared.
- R4: An evtIn bit that is high in the same cycle as statRd is still set in statData after the clearing edge.
- R5: At an edge with enWr high, each wrData bit that is 1 enables its source. Bits that are 0 leave their source unchanged.
- R6: At an edge with disWr high, each wrData bit that is 1 disables its source. Bits that are 0 leave their source unchanged.
- R7: If enWr and disWr are both high, a wrData bit that is 1 leaves its source disabled.
- R8: Bit i of maskData is 1 when source i is disabled and 0 when it is enabled.
- R9: irqOut is a register. After each edge it equals the OR, over all sources, of (status bit AND enabled), using the values that edge produced.
- R10: After a clearing status read, irqOut is 0 in the next cycle unless an enabled event arrived during the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 14 | Single-cycle event pulses, one per source |
| enWr | input | 1 | Enable-write strobe |
| disWr | input | 1 | Disable-write strobe |
| wrData | input | 14 | Write data for both strobes |
| statRd | input | 1 | Status-read strobe; clears status at the edge |
| statData | output | 14 | Current status bits |
| maskData | output | 14 | Mask readback, 1 = disabled |
| irqOut | output | 1 | Combined registered interrupt request |

## Verification
A corrupted status bit shows up on statData in the cycle after the faulty edge. It also changes irqOut whenever that source is enabled. A wrong enable bit shows on maskData one edge after the write. It then shows on irqOut as soon as a matching event is pending. A clear that is lost or misapplied shows on the very next read, as a missing or stale bit.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int NUM_SRC = 14;

  typedef struct packed {
    logic [NUM_SRC-1:0] enableBits;
    logic [NUM_SRC-1:0] disableBits;
    logic               statClear;
  } iscStrobes_t;
endpackage

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int SrcCnt = NUM_SRC
) (
  input  logic              enWr,
  input  logic              disWr,
  input  logic [SrcCnt-1:0] wrData,
  input  logic              statRd,
  output iscStrobes_t       strobes
);
  logic [SrcCnt-1:0] disReq;
  logic [SrcCnt-1:0] enReq;

  always_comb begin
    disReq = disWr ? wrData : '0;
    enReq  = enWr ? wrData : '0;
    strobes.disableBits = disReq;
    // disable has priority over enable on the same bit (R7)
    strobes.enableBits  = enReq & ~disReq;
    strobes.statClear   = statRd;
  end
endmodule

// File: rtl/isc_dpath.sv
module isc_dpath
  import isc_pkg::*;
#(
  parameter int SrcCnt = NUM_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SrcCnt-1:0] evtIn,
  input  iscStrobes_t       strobes,
  output logic [SrcCnt-1:0] statData,
  output logic [SrcCnt-1:0] maskData,
  output logic              irqOut
);
  logic [SrcCnt-1:0] statusQ, statusNext;
  logic [SrcCnt-1:0] enabledQ, enabledNext;
  logic [SrcCnt-1:0] pendNext;
  logic              irqQ;

  for (genvar i = 0; i < SrcCnt; i++) begin : g_cell
    always_comb begin
      statusNext[i]  = (strobes.statClear ? 1'b0 : statusQ[i]) | evtIn[i];
      enabledNext[i] = (enabledQ[i] | strobes.enableBits[i]) & ~strobes.disableBits[i];
      pendNext[i]    = statusNext[i] & enabledNext[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      enabledQ <= '0;
      irqQ     <= 1'b0;
    end else begin
      statusQ  <= statusNext;
      enabledQ <= enabledNext;
      irqQ     <= |pendNext;
    end
  end

  assign statData = statusQ;
  assign maskData = ~enabledQ;
  assign irqOut   = irqQ;

  // R2: a status bit may only rise if its event was present
  p_rise_needs_evt_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(evtIn)) == '0));

  // R3 / R4: after a clearing read only the coincident events remain
  p_clear_keeps_evt_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.statClear |=> (statusQ == $past(evtIn)));

  // R5: enabled bits take effect
  p_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.enableBits) |=> ((enabledQ & $past(strobes.enableBits)) == $past(strobes.enableBits)));

  // R6: disabled bits take effect
  p_disable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.disableBits) |=> ((enabledQ & $past(strobes.disableBits)) == '0));

  // R5 / R6: no write, no change of enables
  p_hold_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.enableBits == '0 && strobes.disableBits == '0) |=> $stable(enabledQ));

  // R9: request matches pending-and-enabled state
  p_irq_or_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == |(statusQ & enabledQ));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isc_pkg::*;
#(
  parameter int SrcCnt = NUM_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SrcCnt-1:0] evtIn,
  input  logic              enWr,
  input  logic              disWr,
  input  logic [SrcCnt-1:0] wrData,
  input  logic              statRd,
  output logic [SrcCnt-1:0] statData,
  output logic [SrcCnt-1:0] maskData,
  output logic              irqOut
);
  iscStrobes_t strobes;

  isc_ctrl #(.SrcCnt(SrcCnt)) ctrl_i (
    .enWr(enWr), .disWr(disWr), .wrData(wrData), .statRd(statRd), .strobes(strobes)
  );

  isc_dpath #(.SrcCnt(SrcCnt)) dpath_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strobes(strobes),
    .statData(statData), .maskData(maskData), .irqOut(irqOut)
  );

  // R7: disable always wins over a simultaneous enable
  p_dis_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && disWr) |=> ((~maskData & $past(wrData)) == '0));
endmodule

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
  localparam int N = 14;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] evtIn = '0;
  logic enWr = 1'b0, disWr = 1'b0, statRd = 1'b0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] statData, maskData;
  logic irqOut;
  int compared = 0;
  int mismatched = 0;
  logic [N-1:0] expMask = '1;

  always #10 clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .enWr(enWr), .disWr(disWr),
    .wrData(wrData), .statRd(statRd), .statData(statData),
    .maskData(maskData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseEvt(input logic [N-1:0] v);
    evtIn = v; tick(); evtIn = '0;
  endtask

  task automatic writeEn(input logic [N-1:0] v);
    wrData = v; enWr = 1'b1; tick(); enWr = 1'b0; wrData = '0;
  endtask

  task automatic writeDis(input logic [N-1:0] v);
    wrData = v; disWr = 1'b1; tick(); disWr = 1'b0; wrData = '0;
  endtask

  task automatic readStat(input logic [N-1:0] exp, input string req);
    statRd = 1'b1;
    check(req, statData, exp);
    tick();
    statRd = 1'b0;
  endtask

  task automatic testReset();
    check("R1 status", statData, 0);
    check("R1 mask", maskData, 14'h3fff);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic testLatchDisabled();
    pulseEvt(14'h0008);
    check("R2 latch while disabled", statData, 14'h0008);
    check("R9 no irq when disabled", irqOut, 0);
    tick();
    check("R2 sticky", statData, 14'h0008);
    readStat(14'h0008, "R3 read value");
    check("R3 cleared", statData, 0);
  endtask

  task automatic testEnableDisable();
    writeEn(14'h0005);
    check("R5 enable", maskData, 14'h3ffa);
    check("R8 polarity", maskData[0], 1'b0);
    writeEn(14'h0000);
    check("R5 zero no effect", maskData, 14'h3ffa);
    writeDis(14'h0000);
    check("R6 zero no effect", maskData, 14'h3ffa);
  endtask

  task automatic testIrqPath();
    pulseEvt(14'h0001);
    check("R9 irq on enabled event", irqOut, 1);
    readStat(14'h0001, "R3 read bit0");
    check("R10 irq drops after read", irqOut, 0);
    pulseEvt(14'h0002);
    check("R9 disabled pending no irq", irqOut, 0);
    writeEn(14'h0002);
    check("R9 irq after enabling pending", irqOut, 1);
    writeDis(14'h0002);
    check("R6 disable", maskData, 14'h3ffa);
    check("R6 irq off after disable", irqOut, 0);
    readStat(14'h0002, "R3 read bit1");
  endtask

  task automatic testCoincident();
    pulseEvt(14'h0010);
    evtIn = 14'h0004;
    readStat(14'h0010, "R4 read returns old");
    evtIn = '0;
    check("R4 coincident kept", statData, 14'h0004);
    check("R10 irq stays on new event", irqOut, 1);
    readStat(14'h0004, "R4 next read");
    check("R10 irq cleared", irqOut, 0);
  endtask

  task automatic testBothWrites();
    writeEn(14'h1000);
    check("R5 enable bit12", maskData, 14'h2ffa);
    wrData = 14'h3000; enWr = 1'b1; disWr = 1'b1;
    tick();
    enWr = 1'b0; disWr = 1'b0; wrData = '0;
    check("R7 disable wins", maskData, 14'h3ffa);
  endtask

  task automatic testAllSources();
    writeEn(14'h3fff);
    check("R8 all enabled", maskData, 0);
    pulseEvt(14'h3fff);
    check("R2 all latched", statData, 14'h3fff);
    check("R9 irq all", irqOut, 1);
    readStat(14'h3fff, "R3 read all");
    check("R3 all cleared", statData, 0);
    check("R10 irq low", irqOut, 0);
  endtask

  initial begin
    #2000000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testLatchDisabled();
    testEnableDisable();
    testIrqPath();
    testCoincident();
    testBothWrites();
    testAllSources();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule